// File: doc/BRIEF.md
# DRAM Rank Clock-Enable Power Controller

This block drives the clock-enable (CKE) lines of one DRAM channel with up to four ranks. A single 32-bit control word, loaded through a plain write port and readable at all times, sets which ranks are fitted, whether power-down is allowed, the shortest time CKE may stay high or low, and how long commands are held back after CKE rises again.

After reset the channel is taken to be in self-refresh: every CKE is low and no command may issue. Software starts the self-refresh exit by writing the start bit together with an exit count. CKE then rises on the fitted ranks and all commands stay blocked until the count has run out. Once active, the controller drops CKE for power-down when the scheduler asks for it and reports idle. When the request goes away it raises CKE again. Reads may issue at once, but non-read commands wait for a programmed number of clocks. Two outputs tell the command scheduler whether a read or a non-read command may issue in the current cycle.

Top module: `cke_power_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000800 (spacing code 2, every other field zero), all CKE outputs are low and both permit outputs are low.
- R2: Writing the word with bit 27 set while in self-refresh makes CKE of the fitted ranks high in the next cycle. Both permits stay low for max(N,1) cycles after CKE rises, where N is bits 9:1 of that same write. Bit 27 always reads back as 0. A start write made in any other state, including during an exit already under way, has no effect.
- R3: In the active state, power-down is entered at the next edge when the power-down request, the idle input and the enable (bit 16) are all 1. Entry drives CKE low, and both permits are low while powered down. With the enable at 0 or the idle input at 0, CKE stays high.
- R4: When the power-down request drops, CKE rises and reads are permitted from the first cycle. Non-read commands are blocked for S cycles, where S is the decoded spacing.
- R5: The spacing code in bits 13:10 decodes to S = code for codes 2 to 9. Every other code decodes to S = 9.
- R6: After CKE falls, it stays low for at least max(L,1) cycles, where L is bits 19:17.
- R7: After CKE rises, it stays high for at least max(H,1) cycles, where H is bits 26:24.
- R8: Bit 20+r marks rank r as fitted. The CKE of an unfitted rank is always low.
- R9: While the lock input is 1, writes leave bits 23:20 unchanged. All other writable bits still update.
- R10: Bits 31:28, 27 and 15:14 always read as 0. Bit 0 and bits 9:1 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_lock_i | input | 1 | Freezes the rank-fitted bits while high |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Current control word |
| pd_req_i | input | 1 | Power-down request, level |
| idle_i | input | 1 | No command pending from the scheduler |
| cke_o | output | 4 | Per-rank clock enable |
| rd_permit_o | output | 1 | A read may issue this cycle |
| nrd_permit_o | output | 1 | A non-read command may issue this cycle |

## Verification
The assertions assume that reset is held for at least one clock edge and that every input is steady around the rising edge. They also assume that the power-down request and the idle input are plain levels that may change in any cycle. The checks on CKE dwell and command blocking depend only on the control word that was in place when a transition started. The stimulus therefore changes inputs only on the falling edge. It rewrites the control word only while CKE is steady and no dwell or spacing window is open, so every measured window belongs to a single setting.

// File: rtl/cke_pkg.sv
package cke_pkg;

  localparam int CW_W      = 32;
  localparam int NUM_RANKS = 4;
  localparam int PW_W      = 3;
  localparam int SPC_W     = 4;
  localparam int SRX_W     = 9;

  localparam int B_START   = 27;
  localparam int B_HI_LSB  = 24;
  localparam int B_POP_LSB = 20;
  localparam int B_LO_LSB  = 17;
  localparam int B_PDEN    = 16;
  localparam int B_SPC_LSB = 10;
  localparam int B_SRX_LSB = 1;

  localparam logic [CW_W-1:0] CW_RESET = 32'h0000_0800;
  localparam logic [CW_W-1:0] CW_WMASK = 32'h07FF_3FFF;
  localparam logic [CW_W-1:0] CW_POPMASK =
    {{(CW_W-B_POP_LSB-NUM_RANKS){1'b0}}, {NUM_RANKS{1'b1}}, {B_POP_LSB{1'b0}}};

  localparam logic [SPC_W-1:0] SPC_MIN = 4'd2;
  localparam logic [SPC_W-1:0] SPC_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_SELFREF = 2'd0,
    ST_SRX     = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_PDOWN   = 2'd3
  } cke_state_e;

  typedef struct packed {
    logic [PW_W-1:0]      hi_min;
    logic [NUM_RANKS-1:0] pop;
    logic [PW_W-1:0]      lo_min;
    logic                 pd_en;
    logic [SPC_W-1:0]     spc_code;
  } cke_cfg_t;

  // Reserved spacing codes fall back to the longest legal spacing.
  function automatic logic [SPC_W-1:0] spacing_clocks(input logic [SPC_W-1:0] code);
    if (code < SPC_MIN || code > SPC_MAX) return SPC_MAX;
    return code;
  endfunction

  function automatic cke_cfg_t unpack_cfg(input logic [CW_W-1:0] w);
    cke_cfg_t c;
    c.hi_min   = w[B_HI_LSB +: PW_W];
    c.pop      = w[B_POP_LSB +: NUM_RANKS];
    c.lo_min   = w[B_LO_LSB +: PW_W];
    c.pd_en    = w[B_PDEN];
    c.spc_code = w[B_SPC_LSB +: SPC_W];
    return c;
  endfunction

  function automatic logic [CW_W-1:0] merge_write(input logic [CW_W-1:0] old_w,
                                                  input logic [CW_W-1:0] new_w,
                                                  input logic            lock);
    logic [CW_W-1:0] m;
    m = lock ? (CW_WMASK & ~CW_POPMASK) : CW_WMASK;
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/cke_cfg_reg.sv
module cke_cfg_reg
  import cke_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CW_W-1:0] wdata_i,
  input  logic            lock_i,
  output logic [CW_W-1:0] word_o,
  output cke_cfg_t        cfg_o
);

  logic [CW_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= CW_RESET;
    else if (we_i) word_q <= merge_write(word_q, wdata_i, lock_i);
  end

  assign word_o = word_q;
  assign cfg_o  = unpack_cfg(word_q);

  // R9: a locked write leaves the rank-fitted bits alone
  a_r9_lock_holds_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && lock_i) |=> (word_q[B_POP_LSB +: NUM_RANKS] == $past(word_q[B_POP_LSB +: NUM_RANKS])));

  // R10: an unlocked write lands the writable bits one cycle later
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !lock_i) |=> ((word_q & CW_WMASK) == ($past(wdata_i) & CW_WMASK)));

endmodule

// File: rtl/cke_down_cnt.sv
module cke_down_cnt #(
  parameter int W       = 4,
  parameter int DONE_AT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] DLIM = W'(DONE_AT);

  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               val_q <= '0;
    else if (load_i)          val_q <= load_val_i;
    else if (val_q != '0)     val_q <= val_q - ONE;
  end

  assign done_o = (val_q <= DLIM);

  // R4, R6, R7: the window shrinks by exactly one per clock until empty
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && val_q != '0) |=> (val_q == $past(val_q) - ONE));

  a_r6_count_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && val_q == '0) |=> (val_q == '0));

endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
  import cke_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pop_lock_i,
  input  logic                 cfg_we_i,
  input  logic [CW_W-1:0]      cfg_wdata_i,
  output logic [CW_W-1:0]      cfg_rdata_o,
  input  logic                 pd_req_i,
  input  logic                 idle_i,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic                 rd_permit_o,
  output logic                 nrd_permit_o
);

  cke_cfg_t   cfg;
  cke_state_e state_q, state_d;
  logic       cke_lvl_q;

  // named internal events
  logic sr_go, srx_done, pd_enter, pd_exit, cke_change;
  logic dwell_ok, srx_last, txp_clear;
  logic [PW_W-1:0]  dwell_load_val;
  logic [SPC_W-1:0] txp_load_val;
  logic [SRX_W-1:0] srx_load_val;

  cke_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .lock_i  (pop_lock_i),
    .word_o  (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  assign sr_go    = cfg_we_i && cfg_wdata_i[B_START] && (state_q == ST_SELFREF);
  assign srx_done = (state_q == ST_SRX) && srx_last;
  assign pd_enter = (state_q == ST_ACTIVE) && pd_req_i && idle_i && cfg.pd_en && dwell_ok;
  assign pd_exit  = (state_q == ST_PDOWN) && (!pd_req_i || !cfg.pd_en) && dwell_ok;
  assign cke_change = sr_go || pd_enter || pd_exit;

  assign dwell_load_val = (sr_go || pd_exit) ? cfg.hi_min : cfg.lo_min;
  assign txp_load_val   = spacing_clocks(cfg.spc_code);
  assign srx_load_val   = cfg_wdata_i[B_SRX_LSB +: SRX_W];

  // CKE level dwell, one transition window at a time
  cke_down_cnt #(.W(PW_W), .DONE_AT(1)) u_dwell (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cke_change),
    .load_val_i (dwell_load_val),
    .done_o     (dwell_ok)
  );

  // exit-to-non-read spacing
  cke_down_cnt #(.W(SPC_W), .DONE_AT(0)) u_txp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (pd_exit),
    .load_val_i (txp_load_val),
    .done_o     (txp_clear)
  );

  // self-refresh exit countdown
  cke_down_cnt #(.W(SRX_W), .DONE_AT(1)) u_srx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (sr_go),
    .load_val_i (srx_load_val),
    .done_o     (srx_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SELFREF: if (sr_go)    state_d = ST_SRX;
      ST_SRX:     if (srx_done) state_d = ST_ACTIVE;
      ST_ACTIVE:  if (pd_enter) state_d = ST_PDOWN;
      ST_PDOWN:   if (pd_exit)  state_d = ST_ACTIVE;
      default:                  state_d = ST_SELFREF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_SELFREF;
      cke_lvl_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sr_go || pd_exit) cke_lvl_q <= 1'b1;
      else if (pd_enter)    cke_lvl_q <= 1'b0;
    end
  end

  assign cke_o        = {NUM_RANKS{cke_lvl_q}} & cfg.pop;
  assign rd_permit_o  = (state_q == ST_ACTIVE);
  assign nrd_permit_o = (state_q == ST_ACTIVE) && txp_clear;

  // R6, R7: the CKE level changes only once the dwell window has closed
  a_r7_dwell_respected: assert property (@(posedge clk) disable iff (!rst_n)
    ((cke_lvl_q != $past(cke_lvl_q)) && ($past(state_q) != ST_SELFREF)) |-> $past(dwell_ok));

  // R4: the first active cycle after power-down never permits non-reads
  a_r4_nrd_blocked_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state_q) == ST_PDOWN) && (state_q == ST_ACTIVE)) |-> !nrd_permit_o);

  // R2: an accepted start raises CKE and enters the exit countdown
  a_r2_srx_start: assert property (@(posedge clk) disable iff (!rst_n)
    sr_go |=> ((state_q == ST_SRX) && cke_lvl_q));

  // R3: CKE is low throughout power-down
  a_r3_pd_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDOWN) |-> !cke_lvl_q);

  // R1: in self-refresh CKE is low and nothing may issue
  a_r1_selfref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELFREF) |-> (!cke_lvl_q && !rd_permit_o));

endmodule

// File: tb/cke_power_ctrl_test.sv
module cke_power_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pop_lock_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        pd_req_i = 1'b0;
  logic        idle_i = 1'b1;
  logic [3:0]  cke_o;
  logic        rd_permit_o;
  logic        nrd_permit_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cke_power_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pop_lock_i   (pop_lock_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .pd_req_i     (pd_req_i),
    .idle_i       (idle_i),
    .cke_o        (cke_o),
    .rd_permit_o  (rd_permit_o),
    .nrd_permit_o (nrd_permit_o)
  );

  // spacing table: high nibble = code written, low nibble = clocks expected
  localparam logic [7:0] SPC_TBL [10] = '{8'h22, 8'h33, 8'h55, 8'h88, 8'h99,
                                          8'h09, 8'h19, 8'hA9, 8'hC9, 8'hF9};

  function automatic logic [31:0] mk(input logic [2:0] hi, input logic [3:0] pop,
                                     input logic [2:0] lo, input logic pden,
                                     input logic [3:0] spc, input logic [8:0] srx,
                                     input logic single, input logic start);
    logic [31:0] w;
    w = '0;
    w[27] = start;  w[26:24] = hi; w[23:20] = pop; w[19:17] = lo;
    w[16] = pden;   w[13:10] = spc; w[9:1] = srx;  w[0] = single;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_wdata_i = w;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_cke(input logic [3:0] val, input int limit);
    for (int i = 0; i < limit && cke_o != val; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int bad;
    logic [31:0] base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 word", cfg_rdata_o, 32'h0000_0800);
    chk("R1 cke", {28'd0, cke_o}, 32'h0);
    chk("R1 permits", {30'd0, rd_permit_o, nrd_permit_o}, 32'h0);

    // R2 configuration without start stays in self-refresh
    base = mk(3'd0, 4'hF, 3'd0, 1'b1, 4'd2, 9'd20, 1'b1, 1'b0);
    write_cfg(base);
    chk("R2 no start cke", {28'd0, cke_o}, 32'h0);
    chk("R10 word readback", cfg_rdata_o, base);

    // R2 self-refresh exit with a repeated start inside the window
    write_cfg(base | 32'h0800_0000);
    chk("R2 cke rises", {28'd0, cke_o}, 32'hF);
    cnt = 0;
    if (!rd_permit_o) cnt++;
    cfg_we_i = 1'b1; cfg_wdata_i = mk(3'd0, 4'hF, 3'd0, 1'b1, 4'd2, 9'd20, 1'b1, 1'b1);
    @(negedge clk);
    cfg_we_i = 1'b0;
    while (!rd_permit_o && cnt < 500) begin cnt++; @(negedge clk); end
    chk("R2 exit window", cnt, 20);
    chk("R2 nrd after exit", {31'd0, nrd_permit_o}, 32'h1);
    chk("R10 start bit reads 0", {31'd0, cfg_rdata_o[27]}, 32'h0);

    // R4/R5 table walk over spacing codes
    for (int t = 0; t < 10; t++) begin
      write_cfg(mk(3'd0, 4'hF, 3'd0, 1'b1, SPC_TBL[t][7:4], 9'd20, 1'b0, 1'b0));
      pd_req_i = 1'b1;
      @(negedge clk);
      wait_cke(4'h0, 20);
      chk("R3 pd entry", {28'd0, cke_o}, 32'h0);
      chk("R3 permits low in pd", {30'd0, rd_permit_o, nrd_permit_o}, 32'h0);
      pd_req_i = 1'b0;
      @(negedge clk);
      cnt = 0; bad = 0;
      while (cke_o == 4'hF && !nrd_permit_o && cnt < 50) begin
        if (!rd_permit_o) bad++;
        cnt++;
        @(negedge clk);
      end
      chk($sformatf("R5 spacing code %0d", SPC_TBL[t][7:4]), cnt, {28'd0, SPC_TBL[t][3:0]});
      chk("R4 reads open at exit", bad, 0);
    end

    // R3 power-down disabled, then not idle
    write_cfg(mk(3'd0, 4'hF, 3'd0, 1'b0, 4'd2, 9'd0, 1'b0, 1'b0));
    pd_req_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 pd disabled keeps cke", {28'd0, cke_o}, 32'hF);
    pd_req_i = 1'b0;
    write_cfg(mk(3'd0, 4'hF, 3'd0, 1'b1, 4'd2, 9'd0, 1'b0, 1'b0));
    idle_i = 1'b0; pd_req_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 busy keeps cke", {28'd0, cke_o}, 32'hF);
    pd_req_i = 1'b0; idle_i = 1'b1;
    @(negedge clk);

    // R6/R7 pulse minimums: low 5, high 3
    write_cfg(mk(3'd3, 4'hF, 3'd5, 1'b1, 4'd2, 9'd0, 1'b0, 1'b0));
    pd_req_i = 1'b1;
    @(negedge clk);
    pd_req_i = 1'b0;
    cnt = 0;
    while (cke_o == 4'h0 && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R6 low dwell", cnt, 5);
    pd_req_i = 1'b1;
    cnt = 0;
    while (cke_o == 4'hF && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R7 high dwell", cnt, 3);
    pd_req_i = 1'b0;
    wait_cke(4'hF, 20);
    chk("R7 back up", {28'd0, cke_o}, 32'hF);

    // R8 unfitted ranks stay low, also across power-down
    write_cfg(mk(3'd0, 4'h5, 3'd0, 1'b1, 4'd2, 9'd0, 1'b0, 1'b0));
    chk("R8 partial population", {28'd0, cke_o}, 32'h5);
    pd_req_i = 1'b1;
    @(negedge clk);
    chk("R8 pd all low", {28'd0, cke_o}, 32'h0);
    pd_req_i = 1'b0;
    wait_cke(4'h5, 20);
    @(negedge clk);
    chk("R8 exit fitted only", {28'd0, cke_o}, 32'h5);

    // R9 lock
    pop_lock_i = 1'b1;
    write_cfg(mk(3'd0, 4'hF, 3'd0, 1'b1, 4'd4, 9'd0, 1'b0, 1'b0));
    chk("R9 pop frozen", {28'd0, cfg_rdata_o[23:20]}, 32'h5);
    chk("R9 other field updates", {28'd0, cfg_rdata_o[13:10]}, 32'h4);
    chk("R9 cke unchanged", {28'd0, cke_o}, 32'h5);

    // R10 reserved bits, R2 start ignored while active
    write_cfg(32'hFFFF_FFFF);
    chk("R10 reserved zero", cfg_rdata_o, 32'h075F_3FFF);
    chk("R2 start ignored when active", {27'd0, cke_o, rd_permit_o}, {27'd0, 4'h5, 1'b1});
    pop_lock_i = 1'b0;

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after rerun", cfg_rdata_o, 32'h0000_0800);
    chk("R1 cke after rerun", {28'd0, cke_o}, 32'h0);
    chk("R1 permits after rerun", {30'd0, rd_permit_o, nrd_permit_o}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule